// File: doc/BRIEF.md
# Grouped-Interrupt GPIO Controller

This block is a memory-mapped general-purpose I/O controller for a configurable number of pins. Each pin owns one 32-bit configuration word. That word holds the output value and a three-bit operating mode. The mode selects either driving the pin or one of several input behaviours, and each input behaviour names its own interrupt trigger. The word also holds a peripheral-function select, pull and input-enable settings, some stored-only pad fields, and a routing group number.

Pin inputs first pass through a two-stage synchroniser. An edge or level detector, chosen by the mode, then raises a per-pin pending flag. Software sees these flags through status words that are banked by routing group, with one word for each block of 32 pins. Software clears a flag by writing a one to its bit. Each group drives one interrupt line, and that line is high while any flag routed to the group is set. Software masks a pin by rewriting its mode to "input, no interrupt", which touches no other pin.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The configuration word of pin n is at byte offset 4*n. Writes keep only the bits in mask 0x00E70FEF: data 0, mode 3:1, function 6:5, pull 8:7, input enable 9, drive 11:10, group 18:16, lock 21, drive 23:22. All other bits read as zero.
- R2: Bit 0 of a configuration read returns the stored data bit when the mode is 1 (output). In every other mode it returns the pin input after the two-flop synchroniser. `pin_out[n]` is the stored data bit, and `pin_oe[n]` is high exactly when the mode is 1.
- R3: Mode encodings for events are: 2 for level high, 3 for level low, 4 for rising edge, 5 for falling edge, and 6 for either edge. Modes 0, 1 and 7 never set a pending flag. An edge is a difference between the current synchronised sample and the previous one.
- R4: In a level mode the flag is set again on every cycle the level is active, so a clear during an active level leaves it set.
- R5: The pending word for group g and pins 32k..32k+31 is at 0x800 + 0x40*g + 4*k, with bit (pin mod 32) for each pin. A flag appears only in the word of the group in the pin's bits 18:16. Events from a pin whose group is NUM_GROUPS or higher are dropped.
- R6: Writing 1 to a pending bit clears that pin's flag, and writing 0 leaves it unchanged.
- R7: When a clear and a new event for the same pin fall in the same cycle, the flag ends up set.
- R8: `irq_out[g]` is the OR of every pending flag whose pin routes to group g.
- R9: Rewriting a pin's mode to 7 stops new pending events from that pin. Other pins' configuration words are unchanged.
- R10: Reset sets every configuration word to mode 7 with all other fields zero, and clears every pending flag and interrupt line.
- R11: Reads at unimplemented or misaligned offsets return zero, and writes there change no state.
- R12: `pin_func[2n+1:2n]` exports bits 6:5 of pin n's configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PINS | Raw pin input levels |
| pin_out | output | NUM_PINS | Driven output values |
| pin_oe | output | NUM_PINS | Output enables |
| pin_func | output | 2*NUM_PINS | Function select per pin |
| irq_out | output | NUM_GROUPS | One interrupt line per group |

## Verification
A software clear of a pending bit and a fresh event on the same pin can land on the same clock edge. The design resolves this in favour of the event. The bench provokes the collision in two ways. It times a one-cycle clear strobe to coincide with the cycle in which a rising edge leaves the synchroniser. It also clears a pin whose level trigger is still active. In both cases the bench judges the result by reading the pending word back and by watching the group's interrupt line: the flag must still be set. A separate sweep over every trigger mode, both idle levels and both transitions on pins in two status words shows that a clear with no event present does take effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W    = 12;
    localparam int WORD_PINS = 32;
    localparam int GRP_W     = 3;

    // Bits a configuration write keeps
    localparam logic [31:0] CFG_KEEP_MASK = 32'h00E7_0FEF;

    typedef enum logic [2:0] {
        MODE_RSVD   = 3'd0,
        MODE_OUT    = 3'd1,
        MODE_LVL_HI = 3'd2,
        MODE_LVL_LO = 3'd3,
        MODE_RISE   = 3'd4,
        MODE_FALL   = 3'd5,
        MODE_BOTH   = 3'd6,
        MODE_IN_OFF = 3'd7
    } pin_mode_e;

    typedef struct packed {
        logic [1:0]       drv_hi;
        logic             lock;
        logic [GRP_W-1:0] grp;
        logic [1:0]       drv_lo;
        logic             in_en;
        logic [1:0]       pull;
        logic [1:0]       func;
        pin_mode_e        mode;
        logic             data;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{
        drv_hi: 2'b00, lock: 1'b0, grp: 3'b000, drv_lo: 2'b00,
        in_en: 1'b0, pull: 2'b00, func: 2'b00,
        mode: MODE_IN_OFF, data: 1'b0
    };

    function automatic pin_cfg_t word_to_cfg(input logic [31:0] w);
        pin_cfg_t c;
        c.data   = w[0];
        c.mode   = pin_mode_e'(w[3:1]);
        c.func   = w[6:5];
        c.pull   = w[8:7];
        c.in_en  = w[9];
        c.drv_lo = w[11:10];
        c.grp    = w[18:16];
        c.lock   = w[21];
        c.drv_hi = w[23:22];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input pin_cfg_t c, input logic bit0);
        logic [31:0] w;
        w        = '0;
        w[0]     = bit0;
        w[3:1]   = c.mode;
        w[6:5]   = c.func;
        w[8:7]   = c.pull;
        w[9]     = c.in_en;
        w[11:10] = c.drv_lo;
        w[18:16] = c.grp;
        w[21]    = c.lock;
        w[23:22] = c.drv_hi;
        return w;
    endfunction

    // Trigger decision for one pin from its mode and two synchronised samples
    function automatic logic trig_fire(input pin_mode_e m, input logic cur, input logic prev);
        logic f;
        case (m)
            MODE_LVL_HI: f = cur;
            MODE_LVL_LO: f = !cur;
            MODE_RISE:   f = cur && !prev;
            MODE_FALL:   f = !cur && prev;
            MODE_BOTH:   f = cur ^ prev;
            default:     f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= raw;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [3*NUM_PINS-1:0] mode_flat,
    input  logic [NUM_PINS-1:0]   cur,
    input  logic [NUM_PINS-1:0]   prev,
    output logic [NUM_PINS-1:0]   fire
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        assign fire[n] = trig_fire(pin_mode_e'(mode_flat[3*n +: 3]), cur[n], prev[n]);
    end
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int NUM_GROUPS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_PINS-1:0]       fire,
    input  logic [GRP_W*NUM_PINS-1:0] grp_flat,
    input  logic [NUM_PINS-1:0]       clr,
    output logic [NUM_PINS-1:0]       pend,
    output logic [NUM_GROUPS-1:0]     irq
);
    localparam logic [GRP_W:0] GRP_LIMIT = (GRP_W+1)'(NUM_GROUPS);

    logic [NUM_PINS-1:0] routed;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_route
        assign routed[n] = fire[n] && ({1'b0, grp_flat[GRP_W*n +: GRP_W]} < GRP_LIMIT);
    end

    // A new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= routed | (pend & ~clr);
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_line
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int n = 0; n < NUM_PINS; n++) begin
                if (grp_flat[GRP_W*n +: GRP_W] == GRP_W'(g)) acc = acc | pend[n];
            end
        end
        assign irq[g] = acc;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 40,
    parameter int NUM_GROUPS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic [NUM_PINS-1:0]     pin_in,
    output logic [NUM_PINS-1:0]     pin_out,
    output logic [NUM_PINS-1:0]     pin_oe,
    output logic [2*NUM_PINS-1:0]   pin_func,
    output logic [NUM_GROUPS-1:0]   irq_out
);
    localparam int NUM_WORDS = (NUM_PINS + WORD_PINS - 1) / WORD_PINS;
    localparam logic [9:0] PIN_LIMIT  = 10'(NUM_PINS);
    localparam logic [4:0] GRP_LIMIT  = 5'(NUM_GROUPS);
    localparam logic [4:0] WORD_LIMIT = 5'(NUM_WORDS);

    // Address decode
    logic       aligned;
    logic [9:0] cfg_sel;
    logic [4:0] grp_sel;
    logic [3:0] word_sel;
    logic       cfg_hit;
    logic       pend_hit;

    assign aligned  = (reg_addr[1:0] == 2'b00);
    assign cfg_sel  = reg_addr[11:2];
    assign grp_sel  = reg_addr[10:6];
    assign word_sel = reg_addr[5:2];
    assign cfg_hit  = aligned && !reg_addr[11] && (cfg_sel < PIN_LIMIT);
    assign pend_hit = aligned && reg_addr[11] && (grp_sel < GRP_LIMIT)
                      && ({1'b0, word_sel} < WORD_LIMIT);

    pin_cfg_t cfg_q [NUM_PINS];

    logic [3*NUM_PINS-1:0]     mode_flat;
    logic [GRP_W*NUM_PINS-1:0] grp_flat;
    logic [NUM_PINS-1:0]       pin_cur;
    logic [NUM_PINS-1:0]       pin_prev;
    logic [NUM_PINS-1:0]       pin_hit;
    logic [NUM_PINS-1:0]       pend_q;
    logic [NUM_PINS-1:0]       pend_clr;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[n] <= CFG_RESET;
            else if (reg_wr && cfg_hit && cfg_sel == 10'(n))
                cfg_q[n] <= word_to_cfg(reg_wdata & CFG_KEEP_MASK);
        end

        assign mode_flat[3*n +: 3]         = cfg_q[n].mode;
        assign grp_flat[GRP_W*n +: GRP_W]  = cfg_q[n].grp;
        assign pin_out[n]                  = cfg_q[n].data;
        assign pin_oe[n]                   = (cfg_q[n].mode == MODE_OUT);
        assign pin_func[2*n +: 2]          = cfg_q[n].func;
        assign pend_clr[n] = reg_wr && pend_hit
                             && (word_sel == 4'(n / WORD_PINS))
                             && (grp_sel == {2'b00, cfg_q[n].grp})
                             && reg_wdata[n % WORD_PINS];
    end

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (pin_in),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .mode_flat (mode_flat),
        .cur       (pin_cur),
        .prev      (pin_prev),
        .fire      (pin_hit)
    );

    gpio_pend_bank #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .fire     (pin_hit),
        .grp_flat (grp_flat),
        .clr      (pend_clr),
        .pend     (pend_q),
        .irq      (irq_out)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (cfg_hit) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                if (cfg_sel == 10'(n))
                    reg_rdata = cfg_to_word(cfg_q[n],
                        (cfg_q[n].mode == MODE_OUT) ? cfg_q[n].data : pin_cur[n]);
            end
        end else if (pend_hit) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                if (word_sel == 4'(n / WORD_PINS) && grp_sel == {2'b00, cfg_q[n].grp})
                    reg_rdata[n % WORD_PINS] = pend_q[n];
            end
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 40,
    parameter int NUM_GROUPS = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_PINS-1:0]       hit,
    input logic [NUM_PINS-1:0]       pend,
    input logic [NUM_PINS-1:0]       clr,
    input logic [3*NUM_PINS-1:0]     mode_flat,
    input logic [GRP_W*NUM_PINS-1:0] grp_flat,
    input logic [NUM_GROUPS-1:0]     irq_out
);
    localparam logic [GRP_W:0] GL = (GRP_W+1)'(NUM_GROUPS);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (hit[n] && ({1'b0, grp_flat[GRP_W*n +: GRP_W]} < GL)) |=> pend[n]);

        // R6
        w1c_chk: assert property (@(posedge clk) disable iff (rst)
            (pend[n] && clr[n] && !hit[n]) |=> !pend[n]);

        // R9
        masked_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_flat[3*n +: 3] == 3'd7) |-> !hit[n]);

        // R3
        pend_origin_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pend[n]) |-> $past(hit[n]));
    end

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (irq_out == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend == '0 && irq_out == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NUM_PINS   (NUM_PINS),
    .NUM_GROUPS (NUM_GROUPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hit       (pin_hit),
    .pend      (pend_q),
    .clr       (pend_clr),
    .mode_flat (mode_flat),
    .grp_flat  (grp_flat),
    .irq_out   (irq_out)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    localparam int NP = 40;
    localparam int NG = 4;
    localparam int NW = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic [11:0]       reg_addr;
    logic              reg_wr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic [NP-1:0]     pin_in;
    logic [NP-1:0]     pin_out;
    logic [NP-1:0]     pin_oe;
    logic [2*NP-1:0]   pin_func;
    logic [NG-1:0]     irq_out;

    int vecs = 0;
    int errs = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP), .NUM_GROUPS(NG)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] cfg_a(input int p);
        return 12'(4 * p);
    endfunction

    function automatic logic [11:0] pend_a(input int g, input int p);
        return 12'(2048 + 64 * g + 4 * (p / 32));
    endfunction

    function automatic logic lvl_on(input int m, input logic l);
        return (m == 2) ? l : (m == 3) ? !l : 1'b0;
    endfunction

    function automatic logic edge_on(input int m, input logic a, input logic b);
        case (m)
            4: return !a && b;
            5: return a && !b;
            6: return a != b;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        vecs++; errs++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int pins [3];
        pins = '{1, 33, 39};
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; pin_in = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R10 reset state
        chk("R10 irq_out", 32'(irq_out), 32'd0);
        chk("R10 pin_oe", 32'(pin_oe), 32'd0);
        for (int g = 0; g < NG; g++)
            for (int k = 0; k < NW; k++) begin
                rd(pend_a(g, 32 * k), d);
                chk("R10 pending word", d, 32'd0);
            end

        // R11 writes to holes and misaligned offsets
        wr(12'h0A0, 32'hFFFF_FFFF);
        wr(12'h7FC, 32'hFFFF_FFFF);
        wr(12'h001, 32'hFFFF_FFFF);
        wr(12'h802, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) begin
            rd(cfg_a(p), d);
            chk("R10/R11 config after reset and hole writes", d, 32'h0000_000E);
        end
        rd(12'h0A0, d); chk("R11 read past last pin", d, 32'd0);
        rd(12'h7FC, d); chk("R11 read top of config space", d, 32'd0);
        rd(12'h001, d); chk("R11 misaligned read", d, 32'd0);
        rd(12'h900, d); chk("R11 group beyond count", d, 32'd0);
        rd(12'h808, d); chk("R11 word beyond pin count", d, 32'd0);

        // R1 / R12 write mask and function export
        wr(cfg_a(3), 32'hFFFF_FFFF);
        rd(cfg_a(3), d);
        chk("R1 stored bits", d, 32'h00E7_0FEE);
        chk("R12 pin_func", 32'(pin_func[7:6]), 32'd3);
        wr(cfg_a(0), 32'h0000_0003);
        rd(cfg_a(0), d);
        chk("R2 output data read", d, 32'h0000_0003);
        chk("R2 pin_out/pin_oe", {30'd0, pin_out[0], pin_oe[0]}, 32'd3);
        wr(cfg_a(0), 32'h0000_0002);
        rd(cfg_a(0), d);
        chk("R2 output data zero", d, 32'h0000_0002);
        chk("R2 pin_out low", 32'(pin_out[0]), 32'd0);

        // R5 group number above the group count drops events
        wr(cfg_a(3), (32'd5 << 16) | (32'd4 << 1));
        pin_in[3] = 1'b1;
        idle(5);
        for (int g = 0; g < NG; g++) begin
            rd(pend_a(g, 3), d);
            chk("R5 out-of-range group dropped", d, 32'd0);
        end
        chk("R5 no line raised", 32'(irq_out), 32'd0);
        wr(cfg_a(3), 32'h0000_000E);

        // R9 masking a level-active pin
        wr(cfg_a(6), 32'h00E2_05AE);
        wr(cfg_a(5), (32'd1 << 16) | (32'd2 << 1));
        pin_in[5] = 1'b1;
        idle(4);
        rd(pend_a(1, 5), d);
        chk("R4 level pending set", 32'(d[5]), 32'd1);
        chk("R8 group 1 line", 32'(irq_out), 32'd2);
        wr(cfg_a(5), (32'd1 << 16) | (32'd7 << 1));
        wr(pend_a(1, 5), 32'd1 << 5);
        idle(3);
        rd(pend_a(1, 5), d);
        chk("R9 masked pin stays clear", 32'(d[5]), 32'd0);
        chk("R9 line low", 32'(irq_out), 32'd0);
        rd(cfg_a(6), d);
        chk("R9 neighbour untouched", d, 32'h00E2_05AE);

        // R7 clear strobe coinciding with a rising edge
        wr(cfg_a(7), (32'd2 << 16) | (32'd4 << 1));
        idle(4);
        wr(pend_a(2, 7), 32'd1 << 7);
        pin_in[7] = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        reg_addr = pend_a(2, 7); reg_wdata = 32'd1 << 7; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(pend_a(2, 7), d);
        chk("R7 event wins over clear", 32'(d[7]), 32'd1);
        chk("R8 group 2 line", 32'(irq_out), 32'd4);
        wr(pend_a(2, 7), 32'd1 << 7);
        rd(pend_a(2, 7), d);
        chk("R6 clear takes effect", 32'(d[7]), 32'd0);
        wr(cfg_a(7), (32'd2 << 16) | (32'd7 << 1));

        // R3 / R4 / R5 / R6 / R8 sweep over modes, pins and transitions
        for (int pi = 0; pi < 3; pi++) begin
            for (int m = 2; m <= 7; m++) begin
                for (int l0 = 0; l0 < 2; l0++) begin
                    for (int l1 = 0; l1 < 2; l1++) begin
                        int p, g, b;
                        logic expa, expb;
                        p = pins[pi];
                        g = (m + p) % NG;
                        b = p % 32;
                        @(negedge clk);
                        pin_in[p] = 1'(l0);
                        wr(cfg_a(p), (32'(g) << 16) | (32'(m) << 1));
                        idle(4);
                        wr(pend_a(g, p), 32'd1 << b);
                        pin_in[p] = 1'(l1);
                        idle(4);
                        expa = lvl_on(m, 1'(l0)) | lvl_on(m, 1'(l1)) | edge_on(m, 1'(l0), 1'(l1));
                        expb = lvl_on(m, 1'(l1));
                        rd(pend_a(g, p), d);
                        chk("R3/R5 pending after transition", 32'(d[b]), 32'(expa));
                        chk("R8 line of routed group", 32'(irq_out), 32'(expa) << g);
                        rd(pend_a((g + 1) % NG, p), d);
                        chk("R5 other group word", 32'(d[b]), 32'd0);
                        rd(cfg_a(p), d);
                        chk("R2 synchronised input bit", 32'(d[0]), 32'(l1));
                        wr(pend_a(g, p), 32'd1 << b);
                        rd(pend_a(g, p), d);
                        chk("R4/R6 pending after clear", 32'(d[b]), 32'(expb));
                        wr(cfg_a(p), (32'(g) << 16) | (32'd7 << 1));
                        wr(pend_a(g, p), 32'd1 << b);
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule